// File: doc/BRIEF.md
# DMA Page Register Address Generator

This block sits beside a pair of four-channel DMA controllers that together serve eight channels. It holds one 8-bit page register for each channel that can carry a transfer, plus one refresh page register. Software reads and writes these registers through a small 8-bit I/O port at fixed addresses. The block also keeps a 16-bit in-page offset counter for each transfer channel. From the page register and offset counter of the active channel it forms a 24-bit system address and a byte-high-enable strobe.

Channels 0 to 3 move bytes. The page supplies A23..A16, the offset supplies A15..A0, and byte-high-enable is the inverse of A0. Channels 5 to 7 move 16-bit words. The page supplies A23..A17, the offset is shifted up one place onto A16..A1, and A0 and byte-high-enable are held low. Channel 4 links the first controller to the second and carries no page register. An offset counter wraps inside its 64 KB or 128 KB page and never carries into the page register.

A small state machine registers the channel select and chooses how the address is formed. Its states are ST_IDLE (entered only at reset; all outputs low), ST_BYTE, ST_WORD and ST_CASCADE. On every clock after reset, the machine moves from any state to ST_BYTE when the select is 0 to 3, to ST_CASCADE when it is 4, and to ST_WORD when it is 5 to 7.

Top module: `dmapg_top`

## Requirements
- R1: After reset, all page registers read 0x00, and sys_addr, bhe, chan_bad, io_rdata and io_nsel are all 0.
- R2: A write with io_wr stores io_wdata in the page register mapped at io_addr: 0x87 ch0, 0x83 ch1, 0x81 ch2, 0x82 ch3, 0x8B ch5, 0x89 ch6, 0x8A ch7, 0x8F refresh. A read with io_rd returns that register on io_rdata, with io_nsel low, on the clock edge that samples io_rd.
- R3: A write to any other I/O address changes no register. A read from any other address returns io_rdata 0x00 with io_nsel high.
- R4: With channel 0 to 3 selected, sys_addr[23:16] equals that channel's page and sys_addr[15:0] equals its offset counter.
- R5: With channel 0 to 3 selected, bhe equals the inverse of sys_addr[0].
- R6: With channel 5 to 7 selected, sys_addr[23:17] equals page bits 7..1, and sys_addr[16:1] equals the offset counter. Page bit 0 has no effect.
- R7: With channel 5 to 7 selected, sys_addr[0] and bhe are both 0.
- R8: ofs_load loads ofs_data into the selected channel's counter. Otherwise ofs_step adds 1, or subtracts 1 when ofs_down is high. The counter wraps from 0xFFFF to 0x0000 and from 0x0000 to 0xFFFF. Other channels' counters are unchanged.
- R9: An offset wrap leaves the page register and the page bits of sys_addr unchanged.
- R10: With channel 4 selected, sys_addr and bhe are 0 and chan_bad is 1. Loads and steps while channel 4 is selected have no effect.
- R11: sys_addr, bhe and chan_bad follow a change of chan_sel on the first clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O address for register access |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | Registered read data |
| io_nsel | output | 1 | Last read hit no page register |
| chan_sel | input | 3 | Active DMA channel |
| ofs_load | input | 1 | Load selected channel's offset counter |
| ofs_data | input | 16 | Offset value to load |
| ofs_step | input | 1 | Transfer done; step selected counter |
| ofs_down | input | 1 | Step direction, 1 = decrement |
| sys_addr | output | 24 | System address A23..A0 |
| bhe | output | 1 | Byte-high-enable |
| chan_bad | output | 1 | Cascade channel selected |

## Verification
Every result of this block is due one clock edge after its stimulus. A page write shows on sys_addr after the write edge. Read data and io_nsel appear at the edge that samples io_rd. A load or step shows on the address after its edge, and a new chan_sel takes effect at the next edge. The bench drives inputs on the falling edge and checks at the following falling edge, so exactly one rising edge lies between stimulus and check. One directed test samples just after the select changes, to confirm the old address is still present.

// File: rtl/dmapg_pkg.sv
package dmapg_pkg;
    localparam int NCH        = 8;
    localparam int PAGE_W     = 8;
    localparam int OFS_W      = 16;
    localparam int ADDR_W     = PAGE_W + OFS_W;
    localparam int CH_W       = $clog2(NCH);
    localparam int CASCADE_CH = 4;   // slot 4 of the page file holds refresh

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYTE,
        ST_WORD,
        ST_CASCADE
    } mode_e;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] idx;
    } io_hit_t;

    function automatic io_hit_t io_decode(input logic [7:0] a);
        io_hit_t r;
        r.hit = 1'b1;
        unique case (a)
            8'h87:   r.idx = 3'd0;
            8'h83:   r.idx = 3'd1;
            8'h81:   r.idx = 3'd2;
            8'h82:   r.idx = 3'd3;
            8'h8F:   r.idx = 3'd4;
            8'h8B:   r.idx = 3'd5;
            8'h89:   r.idx = 3'd6;
            8'h8A:   r.idx = 3'd7;
            default: begin r.hit = 1'b0; r.idx = 3'd0; end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/dmapg_pagefile.sv
module dmapg_pagefile
    import dmapg_pkg::*;
#(
    parameter int N  = NCH,
    parameter int PW = PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           io_addr,
    input  logic [PW-1:0]        io_wdata,
    input  logic                 io_wr,
    input  logic                 io_rd,
    output logic [PW-1:0]        io_rdata,
    output logic                 io_nsel,
    output logic [N-1:0][PW-1:0] page
);
    io_hit_t dec;
    assign dec = io_decode(io_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page     <= '0;
            io_rdata <= '0;
            io_nsel  <= 1'b0;
        end else begin
            if (io_wr && dec.hit)
                page[dec.idx] <= io_wdata;
            if (io_rd) begin
                io_rdata <= dec.hit ? page[dec.idx] : '0;
                io_nsel  <= !dec.hit;
            end
        end
    end
endmodule

// File: rtl/dmapg_ofs_ctr.sv
module dmapg_ofs_ctr
    import dmapg_pkg::*;
#(
    parameter int OW = OFS_W,
    parameter int CW = CH_W,
    parameter int CH = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] chan_sel,
    input  logic          load,
    input  logic [OW-1:0] data,
    input  logic          step,
    input  logic          down,
    output logic [OW-1:0] ofs
);
    logic mine;
    assign mine = (chan_sel == CW'(CH));

    // Plain modular add/subtract: wraps inside the page, no carry out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ofs <= '0;
        else if (mine && load)
            ofs <= data;
        else if (mine && step)
            ofs <= down ? ofs - OW'(1) : ofs + OW'(1);
    end
endmodule

// File: rtl/dmapg_addr_fsm.sv
module dmapg_addr_fsm
    import dmapg_pkg::*;
#(
    parameter int N  = NCH,
    parameter int PW = PAGE_W,
    parameter int OW = OFS_W,
    parameter int CW = CH_W,
    parameter int CC = CASCADE_CH,
    localparam int AW = PW + OW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CW-1:0]        chan_sel,
    input  logic [N-1:0][PW-1:0] page,
    input  logic [N-1:0][OW-1:0] ofs,
    output logic [AW-1:0]        sys_addr,
    output logic                 bhe,
    output logic                 chan_bad
);
    mode_e         state, state_nx;
    logic [CW-1:0] ch_q;
    logic [PW-1:0] pg;
    logic [OW-1:0] of;

    always_comb begin
        if (chan_sel == CW'(CC))
            state_nx = ST_CASCADE;
        else if (chan_sel < CW'(CC))
            state_nx = ST_BYTE;
        else
            state_nx = ST_WORD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ch_q  <= '0;
        end else begin
            state <= state_nx;
            ch_q  <= chan_sel;
        end
    end

    assign pg = page[ch_q];
    assign of = ofs[ch_q];

    always_comb begin
        sys_addr = '0;
        bhe      = 1'b0;
        chan_bad = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_BYTE: begin
                sys_addr = {pg, of};
                bhe      = ~of[0];
            end
            ST_WORD: begin
                sys_addr = {pg[PW-1:1], of, 1'b0};
            end
            ST_CASCADE: begin
                chan_bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dmapg_top.sv
module dmapg_top
    import dmapg_pkg::*;
#(
    parameter int N  = NCH,
    parameter int PW = PAGE_W,
    parameter int OW = OFS_W,
    localparam int CW = $clog2(N),
    localparam int AW = PW + OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    io_addr,
    input  logic [PW-1:0] io_wdata,
    input  logic          io_wr,
    input  logic          io_rd,
    output logic [PW-1:0] io_rdata,
    output logic          io_nsel,
    input  logic [CW-1:0] chan_sel,
    input  logic          ofs_load,
    input  logic [OW-1:0] ofs_data,
    input  logic          ofs_step,
    input  logic          ofs_down,
    output logic [AW-1:0] sys_addr,
    output logic          bhe,
    output logic          chan_bad
);
    logic [N-1:0][PW-1:0] page;
    logic [N-1:0][OW-1:0] ofs;

    dmapg_pagefile #(.N(N), .PW(PW)) u_pages (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_nsel(io_nsel),
        .page(page)
    );

    for (genvar c = 0; c < N; c++) begin : g_ofs
        if (c == CASCADE_CH) begin : g_none
            assign ofs[c] = '0;
        end else begin : g_ctr
            dmapg_ofs_ctr #(.OW(OW), .CW(CW), .CH(c)) u_ctr (
                .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel),
                .load(ofs_load), .data(ofs_data), .step(ofs_step),
                .down(ofs_down), .ofs(ofs[c])
            );
        end
    end

    dmapg_addr_fsm #(.N(N), .PW(PW), .OW(OW), .CW(CW), .CC(CASCADE_CH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .page(page), .ofs(ofs),
        .sys_addr(sys_addr), .bhe(bhe), .chan_bad(chan_bad)
    );
endmodule

// File: rtl/dmapg_chk.sv
module dmapg_chk #(
    parameter int CW = 3,
    parameter int AW = 24,
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_wr,
    input logic [PW-1:0] io_rdata,
    input logic          io_nsel,
    input logic [CW-1:0] chan_sel,
    input logic          ofs_step,
    input logic [AW-1:0] sys_addr,
    input logic          bhe,
    input logic          chan_bad
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_nsel_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_nsel |-> io_rdata == '0);

    assert_cascade_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chan_bad |-> (sys_addr == '0 && !bhe));

    assert_cascade_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(chan_sel) == CW'(4)) |-> chan_bad);

    assert_word_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(chan_sel) > CW'(4)) |-> (!sys_addr[0] && !bhe && !chan_bad));

    assert_byte_bhe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(chan_sel) < CW'(4)) |-> (bhe == !sys_addr[0]));

    assert_page_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ofs_step && !io_wr && chan_sel == $past(chan_sel)
         && $past(chan_sel) < CW'(4)) |=> $stable(sys_addr[AW-1:16]));
endmodule

bind dmapg_top dmapg_chk #(.CW(CW), .AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rdata(io_rdata),
    .io_nsel(io_nsel), .chan_sel(chan_sel), .ofs_step(ofs_step),
    .sys_addr(sys_addr), .bhe(bhe), .chan_bad(chan_bad)
);

// File: tb/tb_dmapg_top.sv
`timescale 1ns/1ps
module tb_dmapg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_addr = '0, io_wdata = '0, io_rdata;
    logic        io_wr = 1'b0, io_rd = 1'b0, io_nsel;
    logic [2:0]  chan_sel = '0;
    logic        ofs_load = 1'b0, ofs_step = 1'b0, ofs_down = 1'b0;
    logic [15:0] ofs_data = '0;
    logic [23:0] sys_addr;
    logic        bhe, chan_bad;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    dmapg_top dut (.*);

    // {chan, page, offset, expected sys_addr, expected bhe}
    localparam logic [51:0] VEC [0:7] = '{
        {3'd0, 8'h12, 16'h3456, 24'h123456, 1'b1},
        {3'd1, 8'hA5, 16'h0001, 24'hA50001, 1'b0},
        {3'd2, 8'hFF, 16'hFFFF, 24'hFFFFFF, 1'b0},
        {3'd3, 8'h00, 16'h8000, 24'h008000, 1'b1},
        {3'd5, 8'h12, 16'h3456, 24'h1268AC, 1'b0},
        {3'd6, 8'h13, 16'h8001, 24'h130002, 1'b0},
        {3'd7, 8'hFF, 16'hFFFF, 24'hFFFFFE, 1'b0},
        {3'd4, 8'h55, 16'h1234, 24'h000000, 1'b0}
    };

    function automatic logic [7:0] port_of(input logic [2:0] c);
        case (c)
            3'd0: return 8'h87;
            3'd1: return 8'h83;
            3'd2: return 8'h81;
            3'd3: return 8'h82;
            3'd5: return 8'h8B;
            3'd6: return 8'h89;
            3'd7: return 8'h8A;
            default: return 8'h8F;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic sel_load(input logic [2:0] c, input logic [15:0] o);
        @(negedge clk); chan_sel = c; ofs_data = o; ofs_load = 1'b1;
        @(negedge clk); ofs_load = 1'b0;
    endtask

    task automatic step(input logic dn);
        @(negedge clk); ofs_down = dn; ofs_step = 1'b1;
        @(negedge clk); ofs_step = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sys_addr", sys_addr, 0);
        chk("R1 bhe/bad", {bhe, chan_bad}, 0);
        chk("R1 rdata/nsel", {io_rdata, io_nsel}, 0);
        rst_n = 1'b1;
        io_read(8'h8A);
        chk("R1 page reset", {io_rdata, io_nsel}, 0);

        // Vector table walk: R4 R5 R6 R7 R10
        for (int i = 0; i < 8; i++) begin
            logic [2:0] c;
            c = VEC[i][51:49];
            if (c != 3'd4) io_write(port_of(c), VEC[i][48:41]);
            sel_load(c, VEC[i][40:25]);
            if (c < 3'd4) begin
                chk("R4 byte address", sys_addr, VEC[i][24:1]);
                chk("R5 byte bhe", bhe, VEC[i][0]);
            end else if (c > 3'd4) begin
                chk("R6 word address", sys_addr, VEC[i][24:1]);
                chk("R7 word a0/bhe", {sys_addr[0], bhe}, VEC[i][0]);
            end else begin
                chk("R10 cascade address", sys_addr, 0);
                chk("R10 cascade flag", {chan_chk_bad(), bhe}, 2'b10);
            end
        end

        // R2: readback of stored pages and refresh register
        io_read(8'h83);
        chk("R2 readback ch1", {io_rdata, io_nsel}, {8'hA5, 1'b0});
        io_write(8'h8F, 8'h3C);
        io_read(8'h8F);
        chk("R2 readback refresh", {io_rdata, io_nsel}, {8'h3C, 1'b0});

        // R3: unmapped write ignored, unmapped read
        io_write(8'h80, 8'h77);
        io_read(8'h80);
        chk("R3 unmapped read", {io_rdata, io_nsel}, {8'h00, 1'b1});
        io_read(8'h81);
        chk("R3 ch2 untouched", {io_rdata, io_nsel}, {8'hFF, 1'b0});

        // R8/R9: wrap up and down inside the page
        sel_load(3'd1, 16'hFFFF);
        step(1'b0);
        chk("R8 up wrap", sys_addr, 24'hA50000);
        chk("R9 page kept up", sys_addr[23:16], 8'hA5);
        step(1'b1);
        chk("R8 down wrap", sys_addr, 24'hA5FFFF);
        sel_load(3'd5, 16'h0000);
        step(1'b1);
        chk("R9 word down wrap", sys_addr, 24'h13FFFE);
        io_read(8'h8B);
        chk("R9 ch5 page kept", io_rdata, 8'h12);

        // R8: other channel not stepped
        @(negedge clk); chan_sel = 3'd0;
        @(negedge clk);
        chk("R8 ch0 unchanged", sys_addr, 24'h123456);

        // R10: load/step on channel 4 ignored, ch0 untouched
        @(negedge clk); chan_sel = 3'd4; ofs_data = 16'h0000; ofs_load = 1'b1;
        @(negedge clk); ofs_load = 1'b0;
        step(1'b0);
        chk("R10 still zero", sys_addr, 0);
        @(negedge clk); chan_sel = 3'd0;
        @(negedge clk);
        chk("R10 ch0 not loaded", sys_addr, 24'h123456);

        // R11: select change takes one edge
        @(negedge clk); chan_sel = 3'd7;
        #1;
        chk("R11 old address held", sys_addr, 24'h123456);
        @(negedge clk);
        chk("R11 new address", sys_addr, 24'hFFFFFE);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    function automatic logic chan_chk_bad();
        return chan_bad;
    endfunction
endmodule